// File: doc/BRIEF.md
# Two-Requester SRAM Access Arbiter

This block places a processor-side requester and a secondary (backdoor) requester, such as a DMA engine, in front of a single-ported synchronous SRAM. Each cycle it picks at most one requester and drives that requester's address, write enable and write data onto the SRAM port. A grant is combinational in the cycle of the request and covers exactly one access. A requester that is not granted simply retries in a later cycle.

A small configuration register holds the arbitration scheme and a write-protect flag. Four schemes can be chosen while traffic is running:
- alternating round robin;
- a biased round robin that gives the backdoor two grants for every processor grant;
- fixed priority with the processor on top;
- fixed priority with the backdoor on top.

With write protection on, a granted write does not reach the array. It still uses its slot and returns an error strobe to the requester instead.

Top module: `sram_arb_top`

## Requirements
- R1: After reset the configuration reads back as 0 (round robin, unprotected), no grant, valid or error strobe is active, and the first contended cycle in mode 00 goes to the processor.
- R2: In any mode at most one grant is active per cycle, a grant goes only to a requesting port, and a port that requests alone is always granted.
- R3: Mode 00 (configuration bits 2:1): on contention, the port that did not receive the most recent grant wins.
- R4: Mode 01: on contention, the backdoor wins unless it has had two or more grants since the last processor grant; under constant contention the order is backdoor, backdoor, processor, repeating.
- R5: Mode 10: on contention the processor always wins.
- R6: Mode 11: on contention the backdoor always wins.
- R7: With write protection set (configuration bit 0), a granted write still takes its grant, leaves the SRAM unchanged and raises the error strobe of that port one cycle after the grant. Reads are unaffected.
- R8: A granted read returns SRAM data on the granted port one cycle after the grant, marked by that port's valid strobe. The other port sees no valid strobe.
- R9: Configuration layout: bit 0 is write protect and bits 2:1 are the mode. Bits 7:3 read as zero and ignore written values.
- R10: A configuration write takes effect for the arbitration decision in the cycle after the write. The grant in the cycle of the write uses the old settings.
- R11: The round-robin pointer and the backdoor grant count advance on every grant, whatever the mode, so a switch between modes starts from the recent grant history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | CFG_W | Configuration write value |
| cfg_rdata | output | CFG_W | Configuration read value |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor request is a write |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_gnt | output | 1 | Processor granted this cycle |
| cpu_rvalid | output | 1 | Processor read data valid |
| cpu_rdata | output | DATA_W | Processor read data |
| cpu_err | output | 1 | Processor bus error strobe |
| bd_req | input | 1 | Backdoor access request |
| bd_we | input | 1 | Backdoor request is a write |
| bd_addr | input | ADDR_W | Backdoor word address |
| bd_wdata | input | DATA_W | Backdoor write data |
| bd_gnt | output | 1 | Backdoor granted this cycle |
| bd_rvalid | output | 1 | Backdoor read data valid |
| bd_rdata | output | DATA_W | Backdoor read data |
| bd_err | output | 1 | Backdoor bus error strobe |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | ADDR_W | SRAM address |
| mem_wdata | output | DATA_W | SRAM write data |
| mem_rdata | input | DATA_W | SRAM read data, one cycle after enable |

## Verification
The hardest situation to reach is a mode change in the middle of contention, where the outcome depends on grant history built up under a different scheme. The bench holds both requests high across configuration writes. It first builds up a known pointer and count in a fixed-priority mode, then switches to a round-robin mode and checks the grant in the cycle of the write and in the cycle after it. Protected writes followed by unprotected reads of the same small address range show that blocked writes leave the array untouched.

// File: rtl/sram_arb_pkg.sv
package sram_arb_pkg;

    typedef enum logic [1:0] {
        ARB_RR      = 2'b00,
        ARB_RR_BD   = 2'b01,
        ARB_FIX_CPU = 2'b10,
        ARB_FIX_BD  = 2'b11
    } arb_mode_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_CPU  = 2'b01,
        SEL_BD   = 2'b10
    } sel_e;

    typedef struct packed {
        arb_mode_e mode;
        logic      wp;
    } arb_cfg_t;

    localparam int CFG_WP_BIT   = 0;
    localparam int CFG_MODE_LSB = 1;
    localparam int CFG_USED     = 3;

    // Winner when only one or neither port asks.
    function automatic sel_e lone_winner(input logic c, input logic b);
        if (c)      return SEL_CPU;
        else if (b) return SEL_BD;
        else        return SEL_NONE;
    endfunction

endpackage

// File: rtl/sram_arb_cfg.sv
module sram_arb_cfg
    import sram_arb_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output arb_cfg_t         cfg
);
    localparam int PAD_W = CFG_W - CFG_USED;

    arb_cfg_t cfg_q;
    logic     cfg_unused;

    assign cfg_unused = ^cfg_wdata[CFG_W-1:CFG_USED];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode <= ARB_RR;
            cfg_q.wp   <= 1'b0;
        end else if (cfg_we) begin
            cfg_q.mode <= arb_mode_e'(cfg_wdata[CFG_MODE_LSB +: 2]);
            cfg_q.wp   <= cfg_wdata[CFG_WP_BIT];
        end
    end

    assign cfg       = cfg_q;
    assign cfg_rdata = {{PAD_W{1'b0}}, cfg_q.mode, cfg_q.wp};

    // R10: settings only move on a write
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_q));
    // R9: a write lands in the register the following cycle
    a_r9_cfg_load: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_rdata[CFG_USED-1:0] == $past(cfg_wdata[CFG_USED-1:0])));

endmodule

// File: rtl/sram_arb_pick.sv
module sram_arb_pick
    import sram_arb_pkg::*;
#(
    parameter int BD_BURST = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  arb_mode_e mode,
    input  logic      cpu_req,
    input  logic      bd_req,
    output sel_e      sel
);
    localparam int STREAK_W = $clog2(BD_BURST + 1);
    localparam logic [STREAK_W-1:0] BURST_L = STREAK_W'(BD_BURST);

    logic                prefer_bd;
    logic [STREAK_W-1:0] bd_streak;
    logic                both;

    assign both = cpu_req && bd_req;

    always_comb begin
        if (!both) begin
            sel = lone_winner(cpu_req, bd_req);
        end else begin
            unique case (mode)
                ARB_RR:      sel = prefer_bd ? SEL_BD : SEL_CPU;
                ARB_RR_BD:   sel = (bd_streak < BURST_L) ? SEL_BD : SEL_CPU;
                ARB_FIX_CPU: sel = SEL_CPU;
                ARB_FIX_BD:  sel = SEL_BD;
                default:     sel = SEL_CPU;
            endcase
        end
    end

    // R11: history advances on every grant in every mode
    always_ff @(posedge clk) begin
        if (rst) begin
            prefer_bd <= 1'b0;
            bd_streak <= '0;
        end else begin
            case (sel)
                SEL_CPU: begin
                    prefer_bd <= 1'b1;
                    bd_streak <= '0;
                end
                SEL_BD: begin
                    prefer_bd <= 1'b0;
                    if (bd_streak < BURST_L) bd_streak <= bd_streak + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R2: a lone requester is always served
    a_r2_lone_served: assert property (@(posedge clk) disable iff (rst)
        (cpu_req ^ bd_req) |-> (sel != SEL_NONE));
    // R3: consecutive contended round-robin cycles alternate
    a_r3_rr_alternate: assert property (@(posedge clk) disable iff (rst)
        (mode == ARB_RR && both && $past(sel == SEL_BD)) |-> (sel == SEL_CPU));
    // R4: backdoor run length never exceeds the burst
    a_r4_streak_cap: assert property (@(posedge clk) disable iff (rst)
        bd_streak <= BURST_L);
    // R5: processor priority holds under contention
    a_r5_fix_cpu: assert property (@(posedge clk) disable iff (rst)
        (mode == ARB_FIX_CPU && cpu_req) |-> (sel == SEL_CPU));
    // R6: backdoor priority holds under contention
    a_r6_fix_bd: assert property (@(posedge clk) disable iff (rst)
        (mode == ARB_FIX_BD && bd_req) |-> (sel == SEL_BD));

endmodule

// File: rtl/sram_arb_resp.sv
module sram_arb_resp
    import sram_arb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp,
    input  sel_e              sel,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              bd_we,
    input  logic [ADDR_W-1:0] bd_addr,
    input  logic [DATA_W-1:0] bd_wdata,
    output logic              cpu_gnt,
    output logic              bd_gnt,
    output logic              cpu_rvalid,
    output logic              cpu_err,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bd_rvalid,
    output logic              bd_err,
    output logic [DATA_W-1:0] bd_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic any_gnt;
    logic win_we;
    logic blocked;

    assign cpu_gnt = (sel == SEL_CPU);
    assign bd_gnt  = (sel == SEL_BD);
    assign any_gnt = cpu_gnt || bd_gnt;

    always_comb begin
        if (bd_gnt) begin
            win_we    = bd_we;
            mem_addr  = bd_addr;
            mem_wdata = bd_wdata;
        end else begin
            win_we    = cpu_we && cpu_gnt;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
        end
    end

    assign blocked = win_we && wp;
    assign mem_en  = any_gnt && !blocked;
    assign mem_we  = any_gnt && win_we && !wp;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_rvalid <= 1'b0;
            bd_rvalid  <= 1'b0;
            cpu_err    <= 1'b0;
            bd_err     <= 1'b0;
        end else begin
            cpu_rvalid <= cpu_gnt && !cpu_we;
            bd_rvalid  <= bd_gnt && !bd_we;
            cpu_err    <= cpu_gnt && cpu_we && wp;
            bd_err     <= bd_gnt && bd_we && wp;
        end
    end

    assign cpu_rdata = mem_rdata;
    assign bd_rdata  = mem_rdata;

    // R2: never two grants at once
    a_r2_gnt_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_gnt, bd_gnt}));
    // R7: a protected array sees no write enable
    a_r7_no_write_when_wp: assert property (@(posedge clk) disable iff (rst)
        wp |-> !mem_we);
    // R8: processor valid follows a processor read grant
    a_r8_cpu_rvalid: assert property (@(posedge clk) disable iff (rst)
        cpu_gnt && !cpu_we |=> cpu_rvalid);
    // R8: backdoor valid only after a backdoor grant
    a_r8_bd_rvalid_src: assert property (@(posedge clk) disable iff (rst)
        !bd_gnt |=> !bd_rvalid);
    // R7: error strobes never overlap a valid on the same port
    a_r7_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(cpu_err && cpu_rvalid) && !(bd_err && bd_rvalid));

endmodule

// File: rtl/sram_arb_top.sv
module sram_arb_top
    import sram_arb_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int CFG_W    = 8,
    parameter int BD_BURST = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_gnt,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_err,
    input  logic              bd_req,
    input  logic              bd_we,
    input  logic [ADDR_W-1:0] bd_addr,
    input  logic [DATA_W-1:0] bd_wdata,
    output logic              bd_gnt,
    output logic              bd_rvalid,
    output logic [DATA_W-1:0] bd_rdata,
    output logic              bd_err,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    arb_cfg_t cfg;
    sel_e     sel;

    sram_arb_cfg #(.CFG_W(CFG_W)) cfg_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg       (cfg)
    );

    sram_arb_pick #(.BD_BURST(BD_BURST)) pick_i (
        .clk     (clk),
        .rst     (rst),
        .mode    (cfg.mode),
        .cpu_req (cpu_req),
        .bd_req  (bd_req),
        .sel     (sel)
    );

    sram_arb_resp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) resp_i (
        .clk        (clk),
        .rst        (rst),
        .wp         (cfg.wp),
        .sel        (sel),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .bd_we      (bd_we),
        .bd_addr    (bd_addr),
        .bd_wdata   (bd_wdata),
        .cpu_gnt    (cpu_gnt),
        .bd_gnt     (bd_gnt),
        .cpu_rvalid (cpu_rvalid),
        .cpu_err    (cpu_err),
        .cpu_rdata  (cpu_rdata),
        .bd_rvalid  (bd_rvalid),
        .bd_err     (bd_err),
        .bd_rdata   (bd_rdata),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata)
    );

    // R2: grants only to requesters
    a_r2_gnt_needs_req: assert property (@(posedge clk) disable iff (rst)
        (cpu_gnt |-> cpu_req) and (bd_gnt |-> bd_req));

endmodule

// File: tb/sram_arb_top_tb_top.sv
`timescale 1ns/1ps
module sram_arb_top_tb_top;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int CW = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [CW-1:0] cfg_rdata;
    logic cpu_req = 0, cpu_we = 0, bd_req = 0, bd_we = 0;
    logic [AW-1:0] cpu_addr = '0, bd_addr = '0;
    logic [DW-1:0] cpu_wdata = '0, bd_wdata = '0;
    logic cpu_gnt, cpu_rvalid, cpu_err, bd_gnt, bd_rvalid, bd_err;
    logic [DW-1:0] cpu_rdata, bd_rdata;
    logic mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    always #4 clk = ~clk;

    sram_arb_top dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_gnt(cpu_gnt), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .cpu_err(cpu_err),
        .bd_req(bd_req), .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata),
        .bd_gnt(bd_gnt), .bd_rvalid(bd_rvalid), .bd_rdata(bd_rdata), .bd_err(bd_err),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // SRAM attached to the block
    logic [DW-1:0] sram [DEPTH];
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) sram[mem_addr] <= mem_wdata;
            mem_rdata <= sram[mem_addr];
        end
    end

    // Reference model state
    int  tests = 0, fails = 0;
    int  m_mode = 0;
    bit  m_wp = 0, m_pref_bd = 0;
    int  m_streak = 0;
    bit  e_cpu_rv = 0, e_bd_rv = 0, e_cpu_err = 0, e_bd_err = 0;
    logic [DW-1:0] e_rdata = '0;
    logic [DW-1:0] shadow [DEPTH];
    int  win = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int predict(input bit c, input bit b);
        if (c && !b) return 1;
        if (b && !c) return 2;
        if (!c && !b) return 0;
        case (m_mode)
            0: return m_pref_bd ? 2 : 1;
            1: return (m_streak < 2) ? 2 : 1;
            2: return 1;
            default: return 2;
        endcase
    endfunction

    function automatic string gnt_tag(input bit c, input bit b);
        if (!(c && b)) return "R2";
        case (m_mode)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // One cycle: inputs already set after a falling edge
    task automatic cycle();
        int got;
        #1;
        win = predict(cpu_req, bd_req);
        got = {30'd0, bd_gnt, cpu_gnt};
        chk(got == ((win == 0) ? 0 : (1 << (win - 1))), gnt_tag(cpu_req, bd_req),
            "grant {bd,cpu}", got, (win == 0) ? 0 : (1 << (win - 1)));
        chk(cpu_rvalid == e_cpu_rv && bd_rvalid == e_bd_rv, "R8", "rvalid {cpu,bd}",
            {cpu_rvalid, bd_rvalid}, {e_cpu_rv, e_bd_rv});
        chk(cpu_err == e_cpu_err && bd_err == e_bd_err, "R7", "err {cpu,bd}",
            {cpu_err, bd_err}, {e_cpu_err, e_bd_err});
        if (e_cpu_rv) chk(cpu_rdata == e_rdata, "R8", "cpu rdata", cpu_rdata, e_rdata);
        if (e_bd_rv)  chk(bd_rdata == e_rdata, "R8", "bd rdata", bd_rdata, e_rdata);
        @(posedge clk);
        e_cpu_rv  = (win == 1) && !cpu_we;
        e_bd_rv   = (win == 2) && !bd_we;
        e_cpu_err = (win == 1) && cpu_we && m_wp;
        e_bd_err  = (win == 2) && bd_we && m_wp;
        if (win == 1) begin
            e_rdata = shadow[cpu_addr];
            if (cpu_we && !m_wp) shadow[cpu_addr] = cpu_wdata;
            m_pref_bd = 1;
            m_streak = 0;
        end else if (win == 2) begin
            e_rdata = shadow[bd_addr];
            if (bd_we && !m_wp) shadow[bd_addr] = bd_wdata;
            m_pref_bd = 0;
            if (m_streak < 2) m_streak++;
        end
        if (cfg_we) begin
            m_wp = cfg_wdata[0];
            m_mode = int'(cfg_wdata[2:1]);
        end
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic set_cfg(input logic [CW-1:0] v);
        cfg_we = 1;
        cfg_wdata = v;
    endtask

    task automatic idle_reqs();
        cpu_req = 0; bd_req = 0; cpu_we = 0; bd_we = 0;
    endtask

    task automatic run_traffic(input int n, input int pc, input int pb, input int pw);
        for (int i = 0; i < n; i++) begin
            cpu_req   = ($urandom % 100) < pc;
            bd_req    = ($urandom % 100) < pb;
            cpu_we    = ($urandom % 100) < pw;
            bd_we     = ($urandom % 100) < pw;
            cpu_addr  = AW'($urandom % 16);
            bd_addr   = AW'($urandom % 16);
            cpu_wdata = $urandom;
            bd_wdata  = $urandom;
            cycle();
        end
        idle_reqs();
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            sram[i] = '0;
            shadow[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        chk(cfg_rdata == 8'h00, "R1", "cfg after reset", cfg_rdata, 0);
        cycle();
        cpu_req = 1; bd_req = 1; cpu_we = 0; bd_we = 0;
        #1;
        chk(cpu_gnt && !bd_gnt, "R1", "first contention to cpu", {bd_gnt, cpu_gnt}, 1);
        cycle();
        idle_reqs();

        // R9: reserved bits read zero
        set_cfg(8'hFF);
        cycle();
        chk(cfg_rdata == 8'h07, "R9", "cfg reserved bits", cfg_rdata, 8'h07);
        set_cfg(8'h00);
        cycle();

        // R3 round robin
        run_traffic(300, 70, 70, 40);
        cpu_req = 1; bd_req = 1;
        for (int i = 0; i < 6; i++) cycle();
        // R4 biased round robin: bits 2:1 = 01
        set_cfg(8'h02);
        cycle();
        for (int i = 0; i < 9; i++) cycle();
        run_traffic(300, 70, 70, 40);
        // R5 fixed cpu
        set_cfg(8'h04);
        cycle();
        run_traffic(300, 70, 70, 40);
        // R6 fixed backdoor
        set_cfg(8'h06);
        cycle();
        run_traffic(300, 70, 70, 40);

        // R10: change under contention, fixed cpu -> fixed backdoor
        set_cfg(8'h04);
        cycle();
        cpu_req = 1; bd_req = 1;
        set_cfg(8'h06);
        #1;
        chk(cpu_gnt, "R10", "old mode in write cycle", cpu_gnt, 1);
        cycle();
        #1;
        chk(bd_gnt, "R10", "new mode next cycle", bd_gnt, 1);
        cycle();

        // R11: history from fixed mode carries into round robin
        set_cfg(8'h04);
        cycle();
        cpu_req = 1; bd_req = 0;
        cycle();
        cpu_req = 1; bd_req = 1;
        set_cfg(8'h00);
        cycle();
        #1;
        chk(bd_gnt, "R11", "pointer updated in fixed mode", bd_gnt, 1);
        cycle();
        idle_reqs();

        // R7 write protection, all schemes
        for (int md = 0; md < 4; md++) begin
            set_cfg(CW'((md << 1) | 1));
            cycle();
            run_traffic(200, 60, 60, 60);
        end
        set_cfg(8'h00);
        cycle();
        // R7: read back array after protected writes
        for (int a = 0; a < 16; a++) begin
            cpu_req = 1; cpu_we = 0; cpu_addr = AW'(a);
            cycle();
        end
        idle_reqs();
        run_traffic(300, 50, 50, 30);
        cycle();
        cycle();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule